// File: doc/BRIEF.md
# Pointer-Register SMBus Slave Front End

This block is the serial-bus slave side of a monitoring chip's 8-bit register file. The clock and data lines are oversampled by the system clock and cleaned up before any bus event is detected. The block detects START and STOP and checks a 7-bit slave address. The two low bits of that address come from a three-level configuration strap, which is read once after reset. The block acknowledges bytes by pulling the data line low through an open-drain enable.

On the register side it presents a pointer and a one-cycle write strobe with its data, and it takes the byte that the register file returns for the current pointer. In a write transfer, the first byte after the address always lands in the pointer. A second byte, if sent, is written to the register that the pointer selects. A read transfer returns the byte at the current pointer and leaves the pointer alone. Repeated reads therefore need no new pointer write.

Top module: `smbus_ptr_slave`

## Requirements
- R1: The slave address is 7 bits, sent MSB first and followed by a direction bit (0 = write, 1 = read). Its upper five bits are 01011 and its low two bits come from the strap.
- R2: The strap input `strapIn` is encoded as 00 = tied low, 01 = open, 10 = tied high, 11 = open. These give address low bits 10, 00, 01 and 00 respectively.
- R3: The strap is captured once, on the first clock after reset is released. Later strap changes do not alter the address until the next reset.
- R4: In a write transfer, the first byte after the address is loaded into `regPtr` and raises no write strobe.
- R5: The second byte of a write transfer produces exactly one `regWe` pulse of one clock, with `regWdata` equal to that byte and `regPtr` selecting the target register.
- R6: A read transfer shifts out the `regRdata` byte for the current pointer, MSB first. `regPtr` stays unchanged through the read and any later reads.
- R7: The slave drives an ACK (data line low) in the ninth clock of every matching address byte and of the first two bytes of a write transfer. A third or later write byte is not acknowledged and causes no strobe.
- R8: When the master NACKs a read byte, the slave releases the data line and stays released until the next START.
- R9: After an address that does not match, the slave never drives the data line, changes no pointer and raises no strobe until the next START.
- R10: A falling data line while the clock is high is a START, also in the middle of a transfer (repeated START). A rising data line while the clock is high is a STOP, which returns the slave to idle.
- R11: Each bus line passes a two-flop synchronizer and a filter that changes its output only after three equal consecutive samples. A pulse of two system clocks or less on either line is ignored.
- R12: Out of reset `sdaOe` is 0, `regWe` is 0 and `regPtr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as sensed |
| sdaIn | input | 1 | Bus data line as sensed (wired-AND level) |
| strapIn | input | 2 | Three-level strap state: 00 low, 01 open, 10 high |
| sdaOe | output | 1 | 1 = pull the data line low |
| regPtr | output | 8 | Current register pointer |
| regWe | output | 1 | One-cycle register write strobe |
| regWdata | output | 8 | Data for the register write |
| regRdata | input | 8 | Register file contents at `regPtr` |

## Verification
The bench targets the places where a pointer-based slave typically goes wrong.

- **First write byte.** A design that treats the first write byte as data would raise `regWe` when only the pointer is set.
- **Reads and the pointer.** A design that auto-increments or reloads the pointer on a read would return the wrong byte on a second read without a new pointer write.
- **Extra write bytes.** The bench sends a third write byte. A slave that keeps acknowledging would write that byte into the wrong register.
- **Address and strap.** Foreign addresses are sent, and the strap is changed both between resets and without a reset. A slave that samples the strap continuously, or that stays awake after a mismatch, would answer the wrong address.
- **Input filtering.** Two-clock dips on the data line test the filter. An unfiltered front end would see a START in such a dip and acknowledge a byte clocked without a real START.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } smbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic wrData;
    logic oeAck;
    logic oeOff;
    logic loadTx;
    logic shiftTx;
  } smbCmd_t;

  // bus events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
  } smbEvt_t;

  // strap state: 00 tied low, 01 open, 10 tied high, 11 open
  function automatic logic [1:0] strapDecode(input logic [1:0] s);
    case (s)
      2'b00:   strapDecode = 2'b10;
      2'b10:   strapDecode = 2'b01;
      default: strapDecode = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/smb_dp.sv
module smb_dp
  import smb_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC = 2,
  parameter int FILT = 3,
  parameter logic [4:0] ADDR_HI = 5'b01011
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic [1:0]    strapIn,
  input  smbCmd_t       cmd,
  output smbEvt_t       evt,
  output logic          rwBit,
  output logic          addrHit,
  output logic          sdaOe,
  output logic [DW-1:0] regPtr,
  output logic          regWe,
  output logic [DW-1:0] regWdata,
  input  logic [DW-1:0] regRdata
);

  logic [1:0] lineIn;
  logic [1:0] lineF;
  assign lineIn = {sdaIn, sclIn};

  // synchronizer plus majority-free agreement filter per line
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [SYNC-1:0] syncQ;
    logic [FILT-1:0] histQ;
    logic            fQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        histQ <= '1;
        fQ    <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC-2:0], lineIn[g]};
        histQ <= {histQ[FILT-2:0], syncQ[SYNC-1]};
        if (&histQ)       fQ <= 1'b1;
        else if (~|histQ) fQ <= 1'b0;
      end
    end
    assign lineF[g] = fQ;
  end

  logic sclF, sdaF, sclP, sdaP;
  assign sclF = lineF[0];
  assign sdaF = lineF[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclF;
      sdaP <= sdaF;
    end
  end

  always_comb begin
    evt.sclRise  = sclF & ~sclP;
    evt.sclFall  = ~sclF & sclP;
    evt.startDet = sclF & sclP & sdaP & ~sdaF;
    evt.stopDet  = sclF & sclP & ~sdaP & sdaF;
    evt.sdaBit   = sdaF;
  end

  // strap captured once after reset
  logic       strapDone;
  logic [1:0] addrLo;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapDone <= 1'b0;
      addrLo    <= 2'b00;
    end else if (!strapDone) begin
      strapDone <= 1'b1;
      addrLo    <= strapDecode(strapIn);
    end
  end

  logic [DW-1:0] rxSh, txSh, ptrQ, wdataQ;
  logic          weQ, oeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh   <= '0;
      txSh   <= '0;
      ptrQ   <= '0;
      wdataQ <= '0;
      weQ    <= 1'b0;
      oeQ    <= 1'b0;
    end else begin
      if (cmd.shiftIn) rxSh <= {rxSh[DW-2:0], sdaF};
      if (cmd.loadPtr) ptrQ <= rxSh;
      weQ <= cmd.wrData;
      if (cmd.wrData) wdataQ <= rxSh;
      if (cmd.loadTx) begin
        txSh <= regRdata;
        oeQ  <= ~regRdata[DW-1];
      end else if (cmd.shiftTx) begin
        txSh <= {txSh[DW-2:0], 1'b0};
        oeQ  <= ~txSh[DW-2];
      end else if (cmd.oeAck) begin
        oeQ <= 1'b1;
      end else if (cmd.oeOff) begin
        oeQ <= 1'b0;
      end
    end
  end

  assign rwBit    = rxSh[0];
  assign addrHit  = (rxSh[DW-1:1] == {ADDR_HI, addrLo});
  assign sdaOe    = oeQ;
  assign regPtr   = ptrQ;
  assign regWe    = weQ;
  assign regWdata = wdataQ;

  assert_strap_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    strapDone |=> $stable(addrLo));
  assert_we_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);
  assert_we_acked_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> sdaOe);
  assert_start_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    evt.startDet |=> !sdaOe);

endmodule

// File: rtl/smb_ctl.sv
module smb_ctl
  import smb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  smbEvt_t evt,
  input  logic    rwBit,
  input  logic    addrHit,
  output smbCmd_t cmd
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  smbState_e st, stN;
  logic [CW-1:0] bitCnt, cntN;
  logic [1:0]    byteIdx, idxN;
  logic          rwQ, rwN, nackQ, nackN;

  always_comb begin
    cmd   = '0;
    stN   = st;
    cntN  = bitCnt;
    idxN  = byteIdx;
    rwN   = rwQ;
    nackN = nackQ;
    if (evt.startDet) begin
      stN = ST_ADDR;
      cntN = '0;
      cmd.oeOff = 1'b1;
    end else if (evt.stopDet) begin
      stN = ST_IDLE;
      cmd.oeOff = 1'b1;
    end else begin
      case (st)
        ST_ADDR: begin
          if (evt.sclRise) begin
            cmd.shiftIn = 1'b1;
            cntN = bitCnt + CW'(1);
          end else if (evt.sclFall && bitCnt == LAST) begin
            cntN = '0;
            if (addrHit) begin
              cmd.oeAck = 1'b1;
              rwN = rwBit;
              stN = ST_ADDR_ACK;
            end else begin
              stN = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (evt.sclFall) begin
            idxN = 2'd0;
            if (rwQ) begin
              cmd.loadTx = 1'b1;
              stN = ST_RD;
            end else begin
              cmd.oeOff = 1'b1;
              stN = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (evt.sclRise) begin
            cmd.shiftIn = 1'b1;
            cntN = bitCnt + CW'(1);
          end else if (evt.sclFall && bitCnt == LAST) begin
            cntN = '0;
            if (byteIdx == 2'd0) begin
              cmd.loadPtr = 1'b1;
              cmd.oeAck = 1'b1;
              stN = ST_WR_ACK;
            end else if (byteIdx == 2'd1) begin
              cmd.wrData = 1'b1;
              cmd.oeAck = 1'b1;
              stN = ST_WR_ACK;
            end else begin
              stN = ST_SKIP;
            end
          end
        end
        ST_WR_ACK: begin
          if (evt.sclFall) begin
            cmd.oeOff = 1'b1;
            idxN = byteIdx + 2'd1;
            stN = ST_WR;
          end
        end
        ST_RD: begin
          if (evt.sclRise) begin
            cntN = bitCnt + CW'(1);
          end else if (evt.sclFall) begin
            if (bitCnt == LAST) begin
              cmd.oeOff = 1'b1;
              cntN = '0;
              stN = ST_RD_ACK;
            end else begin
              cmd.shiftTx = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (evt.sclRise) begin
            nackN = evt.sdaBit;
          end else if (evt.sclFall) begin
            if (nackQ) begin
              stN = ST_SKIP;
            end else begin
              cmd.loadTx = 1'b1;
              stN = ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      bitCnt  <= '0;
      byteIdx <= 2'd0;
      rwQ     <= 1'b0;
      nackQ   <= 1'b0;
    end else begin
      st      <= stN;
      bitCnt  <= cntN;
      byteIdx <= idxN;
      rwQ     <= rwN;
      nackQ   <= nackN;
    end
  end

  assert_skip_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SKIP && !evt.startDet) |=> (st == ST_SKIP || st == ST_IDLE));
  assert_read_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RD || st == ST_RD_ACK) |-> (!cmd.loadPtr && !cmd.wrData));
  assert_bitcnt_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST);
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (evt.stopDet && !evt.startDet) |=> st == ST_IDLE);

endmodule

// File: rtl/smbus_ptr_slave.sv
module smbus_ptr_slave
  import smb_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC = 2,
  parameter int FILT = 3,
  parameter logic [4:0] ADDR_HI = 5'b01011
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic [1:0]    strapIn,
  output logic          sdaOe,
  output logic [DW-1:0] regPtr,
  output logic          regWe,
  output logic [DW-1:0] regWdata,
  input  logic [DW-1:0] regRdata
);

  smbCmd_t cmd;
  smbEvt_t evt;
  logic    rwBit, addrHit;

  smb_dp #(.DW(DW), .SYNC(SYNC), .FILT(FILT), .ADDR_HI(ADDR_HI)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapIn(strapIn),
    .cmd(cmd), .evt(evt), .rwBit(rwBit), .addrHit(addrHit), .sdaOe(sdaOe),
    .regPtr(regPtr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata)
  );

  smb_ctl #(.DW(DW)) uCtl (
    .clk(clk), .rstN(rstN), .evt(evt), .rwBit(rwBit), .addrHit(addrHit),
    .cmd(cmd)
  );

endmodule

// File: tb/sim_smbus_ptr_slave.sv
`timescale 1ns/1ps
module sim_smbus_ptr_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] strapIn = 2'b01;
  logic sdaOe, regWe;
  logic [7:0] regPtr, regWdata, regRdata;
  logic sdaBus;
  assign sdaBus = sdaM & ~sdaOe;

  smbus_ptr_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapIn(strapIn),
    .sdaOe(sdaOe), .regPtr(regPtr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata)
  );

  logic [7:0] rfile [256];
  logic [7:0] shadow [256];
  int weCnt = 0;
  int checks = 0, fails = 0;
  assign regRdata = rfile[regPtr];
  always @(posedge clk) begin
    if (rstN && regWe) begin
      rfile[regPtr] <= regWdata;
      weCnt++;
    end
  end

  function automatic logic [6:0] expAddr(input logic [1:0] s);
    logic [1:0] lo;
    lo = (s == 2'b00) ? 2'b10 : (s == 2'b10) ? 2'b01 : 2'b00;
    return {5'b01011, lo};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q); sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(Q); sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(Q);
  endtask

  task automatic wrByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitClk(Q); sclM = 1'b1; waitClk(2 * Q); sclM = 1'b0; waitClk(Q);
    end
    sdaM = 1'b1; waitClk(Q); sclM = 1'b1; waitClk(Q);
    ack = ~sdaBus;
    waitClk(Q); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic rdByte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitClk(Q); sclM = 1'b1; waitClk(Q);
      d[i] = sdaBus;
      waitClk(Q); sclM = 1'b0; waitClk(Q);
    end
    sdaM = nack; waitClk(Q); sclM = 1'b1; waitClk(2 * Q); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic doReset(input logic [1:0] s);
    rstN = 1'b0; strapIn = s; sclM = 1'b1; sdaM = 1'b1;
    waitClk(5); rstN = 1'b1; waitClk(5);
  endtask

  logic ackA, ackB, ackC;
  logic [7:0] rd;

  task automatic setPtr(input logic [6:0] a, input logic [7:0] p);
    busStart(); wrByte({a, 1'b0}, ackA); wrByte(p, ackB); busStop();
  endtask

  task automatic wrReg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d);
    busStart(); wrByte({a, 1'b0}, ackA); wrByte(p, ackB); wrByte(d, ackC); busStop();
  endtask

  task automatic rdReg(input logic [6:0] a);
    busStart(); wrByte({a, 1'b1}, ackA);
    if (ackA) rdByte(1'b1, rd); else rd = 8'hxx;
    busStop();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int seed, w0, p, d;
    seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) begin
      rfile[i] = 8'((i * 37 + 5) & 8'hff);
      shadow[i] = rfile[i];
    end
    doReset(2'b01);
    // R12 reset state
    chk("R12 oe", int'(sdaOe), 0);
    chk("R12 we", int'(regWe), 0);
    chk("R12 ptr", int'(regPtr), 0);

    // R1 / R4 pointer write only
    w0 = weCnt;
    setPtr(expAddr(2'b01), 8'h3A);
    chk("R1 addr ack", int'(ackA), 1);
    chk("R7 ptr ack", int'(ackB), 1);
    chk("R4 ptr value", int'(regPtr), 8'h3A);
    chk("R4 no strobe", weCnt - w0, 0);

    // R5 data write
    w0 = weCnt;
    wrReg(expAddr(2'b01), 8'h3A, 8'h5C); shadow[8'h3A] = 8'h5C;
    chk("R7 data ack", int'(ackC), 1);
    chk("R5 one strobe", weCnt - w0, 1);
    chk("R5 content", int'(rfile[8'h3A]), 8'h5C);

    // R6 / R8 read
    rdReg(expAddr(2'b01));
    chk("R6 read data", int'(rd), 8'h5C);
    chk("R6 ptr kept", int'(regPtr), 8'h3A);
    chk("R8 released", int'(sdaOe), 0);
    rdReg(expAddr(2'b01));
    chk("R6 second read", int'(rd), 8'h5C);

    // R7 third write byte refused
    w0 = weCnt;
    busStart(); wrByte({expAddr(2'b01), 1'b0}, ackA); wrByte(8'h10, ackB);
    wrByte(8'h77, ackC); shadow[8'h10] = 8'h77;
    wrByte(8'h99, ackA); busStop();
    chk("R7 third nack", int'(ackA), 0);
    chk("R7 one strobe", weCnt - w0, 1);
    chk("R5 target", int'(rfile[8'h10]), 8'h77);

    // R9 foreign address
    w0 = weCnt;
    busStart(); wrByte({expAddr(2'b10), 1'b0}, ackA); wrByte(8'h55, ackB);
    wrByte(8'h66, ackC); busStop();
    chk("R9 addr nack", int'(ackA), 0);
    chk("R9 byte nack", int'(ackB | ackC), 0);
    chk("R9 ptr kept", int'(regPtr), 8'h10);
    chk("R9 no strobe", weCnt - w0, 0);

    // R10 repeated start: pointer then read
    busStart(); wrByte({expAddr(2'b01), 1'b0}, ackA); wrByte(8'h3A, ackB);
    busStart(); wrByte({expAddr(2'b01), 1'b1}, ackC); rdByte(1'b1, rd); busStop();
    chk("R10 rs ack", int'(ackC), 1);
    chk("R10 rs data", int'(rd), 8'h5C);

    // R11 short dip is not a START
    waitClk(Q); sdaM = 1'b0; waitClk(2); sdaM = 1'b1; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
    wrByte({expAddr(2'b01), 1'b0}, ackA);
    busStop();
    chk("R11 glitch ignored", int'(ackA), 0);
    // R10 a long dip is a START
    waitClk(Q); sdaM = 1'b0; waitClk(6); sclM = 1'b0; waitClk(Q);
    wrByte({expAddr(2'b01), 1'b1}, ackA);
    if (ackA) rdByte(1'b1, rd);
    busStop();
    chk("R10 long dip start", int'(ackA), 1);

    // R3 strap change without reset
    strapIn = 2'b10; waitClk(4);
    rdReg(expAddr(2'b01));
    chk("R3 old addr kept", int'(ackA), 1);
    rdReg(expAddr(2'b10));
    chk("R3 new addr ignored", int'(ackA), 0);

    // R2 strap decoding after reset
    doReset(2'b10);
    rdReg(expAddr(2'b10));
    chk("R2 high strap", int'(ackA), 1);
    rdReg(expAddr(2'b01));
    chk("R2 open addr off", int'(ackA), 0);
    doReset(2'b00);
    rdReg(expAddr(2'b00));
    chk("R2 low strap", int'(ackA), 1);
    doReset(2'b11);
    rdReg(7'b0101100);
    chk("R2 code 11 open", int'(ackA), 1);

    // random write/read traffic
    for (int it = 0; it < 16; it++) begin
      p = int'($urandom() % 256);
      d = int'($urandom() % 256);
      wrReg(expAddr(2'b11), 8'(p), 8'(d)); shadow[p] = 8'(d);
      chk("R5 rand ack", int'(ackA & ackB & ackC), 1);
      p = int'($urandom() % 256);
      setPtr(expAddr(2'b11), 8'(p));
      rdReg(expAddr(2'b11));
      chk("R6 rand read", int'(rd), int'(shadow[p]));
      chk("R6 rand ptr", int'(regPtr), p);
    end
    finishRun();
  end
endmodule